// File: doc/BRIEF.md
# Dual DAC Register Interface

This block is the host-facing register logic that sits in front of two digital-to-analog converter channels. The host reaches it through a small byte/word register port. Each channel keeps a two-byte holding register and a committed output code. A separate register holds a 2-bit output range code for each channel. The committed codes and range codes leave the block as parallel buses toward the converters. Each channel also has a one-cycle strobe that marks a change of its committed code.

A strap input picks the commit policy. With the strap low, each channel commits on its own when its high byte is written, or when a full word is written to it. With the strap high, writes only fill the holding registers. A host read of any converter register then moves both held values to the outputs on the same clock edge.

The `DAC_BITS` parameter selects between two variants. In the 16-bit variant the code is the full held word and the range register has no function. In the 12-bit variant the code is the upper twelve bits of the held word, the low nibble is ignored, and the range codes are live.

Top module: `dual_dac_regs`

## Requirements
- R1: After reset, both codes, both range codes, both update strobes and `rdata` are zero.
- R2: Channel n takes its low byte at offset 4+2n and its high byte at offset 5+2n, from `wdata[7:0]` in byte writes. A low-byte write never changes a committed code.
- R3: With `xfer_mode`=0, a write to a channel's high-byte offset commits {written byte, held low byte} to that channel in the same edge. Reads commit nothing in this mode.
- R4: A word write (`wr_word`=1) to offset 4+2n loads both held bytes from `wdata` at once. With `xfer_mode`=0 it commits `wdata` to that channel at that edge.
- R5: With `xfer_mode`=1, writes commit nothing. An `rd_en` at any offset 4 to 7 commits both channels' held values at the same edge.
- R6: If a commit read and a holding-register write fall in the same cycle with `xfer_mode`=1, the commit uses the values held before that write, and the write still lands in the holding register.
- R7: With `DAC_BITS`=12, the code is bits 15:4 of the held word, and the low four bits have no effect on the code or the strobe.
- R8: A write to offset 0xA sets channel 0's range from bits 5:4 and channel 1's range from bits 7:6 (0 = ±5 V, 1 = ±10 V, 2 = 0–5 V, 3 = 0–10 V). Other bits and other offsets leave the ranges unchanged.
- R9: With `DAC_BITS`=16, both range outputs stay zero whatever is written to offset 0xA.
- R10: A channel's update strobe is high for exactly the one cycle in which its code takes a new value. A commit of an unchanged value raises no strobe.
- R11: On `rd_en`, `rdata` is loaded at the next edge as follows: the held word for a low-byte offset, {8'h00, held high byte} for a high-byte offset, {8'h00, ranges in bits 7:4, 4'h0} for offset 0xA, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_mode | input | 1 | Strap: 0 commits per channel, 1 commits both channels on a read |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = 16-bit write, 0 = byte write on `wdata[7:0]` |
| wdata | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 16 | Registered read data |
| dac0_code | output | DAC_BITS | Committed code, channel 0 |
| dac0_range | output | 2 | Range code, channel 0 |
| dac0_upd | output | 1 | Code-change strobe, channel 0 |
| dac1_code | output | DAC_BITS | Committed code, channel 1 |
| dac1_range | output | 2 | Range code, channel 1 |
| dac1_upd | output | 1 | Code-change strobe, channel 1 |

## Verification
The case where two functions meet in one cycle is a joint-commit read that arrives together with a write to the holding register being committed. The bench provokes it in transfer mode by raising `rd_en` and a word write to channel 0's low offset on the same edge. It then expects the earlier held word on the output. A plain read on the next cycle must then bring out the newly written word. The check is made on both the 16-bit and the 12-bit instance, and the checker also compares each joint commit with the held value of the cycle before.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned HOST_W = 16;

  typedef enum logic [1:0] {
    RNG_BIP_5  = 2'd0,
    RNG_BIP_10 = 2'd1,
    RNG_UNI_5  = 2'd2,
    RNG_UNI_10 = 2'd3
  } dac_range_e;

  typedef struct packed {
    logic lo_wr;
    logic hi_wr;
    logic word_wr;
    logic rd_hit;
  } ch_ctl_t;
endpackage

// File: rtl/dacif_decode.sv
module dacif_decode
  import dacif_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned CH_BASE    = 4,
  parameter int unsigned RANGE_ADDR = 10
) (
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output ch_ctl_t [NUM_CH-1:0] ctl,
  output logic              rng_wr
);
  localparam int unsigned LAST_ADDR = CH_BASE + 2 * NUM_CH - 1;

  logic dac_rd;

  assign dac_rd = rd_en && (addr >= ADDR_W'(CH_BASE)) && (addr <= ADDR_W'(LAST_ADDR));
  assign rng_wr = wr_en && (addr == ADDR_W'(RANGE_ADDR));

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      ctl[i]         = '0;
      ctl[i].lo_wr   = wr_en && !wr_word && (addr == ADDR_W'(CH_BASE + 2 * i));
      ctl[i].word_wr = wr_en &&  wr_word && (addr == ADDR_W'(CH_BASE + 2 * i));
      ctl[i].hi_wr   = wr_en && (addr == ADDR_W'(CH_BASE + 2 * i + 1));
      ctl[i].rd_hit  = dac_rd;
    end
  end
endmodule

// File: rtl/dacif_channel.sv
module dacif_channel
  import dacif_pkg::*;
#(
  parameter int unsigned DAC_BITS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                xfer_mode,
  input  ch_ctl_t             ctl,
  input  logic [HOST_W-1:0]   wdata,
  output logic [HOST_W-1:0]   hold,
  output logic [DAC_BITS-1:0] code,
  output logic                upd
);
  localparam int unsigned DROP_BITS = HOST_W - DAC_BITS;

  logic [7:0]          hold_lo;
  logic [7:0]          hold_hi;
  logic                commit_en;
  logic [HOST_W-1:0]   commit_word;
  logic [DAC_BITS-1:0] next_code;

  assign hold = {hold_hi, hold_lo};

  // Commit source: transfer mode uses the pre-edge holding value, so a
  // write landing in the same cycle is not part of this commit.
  always_comb begin
    commit_en   = 1'b0;
    commit_word = hold;
    if (xfer_mode) begin
      commit_en   = ctl.rd_hit;
      commit_word = hold;
    end else if (ctl.word_wr) begin
      commit_en   = 1'b1;
      commit_word = wdata;
    end else if (ctl.hi_wr) begin
      commit_en   = 1'b1;
      commit_word = {wdata[7:0], hold_lo};
    end
  end

  assign next_code = commit_word[HOST_W-1 -: DAC_BITS];

  generate
    if (DROP_BITS > 0) begin : g_drop
      logic unused_low;
      assign unused_low = ^commit_word[DROP_BITS-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_lo <= '0;
      hold_hi <= '0;
      code    <= '0;
      upd     <= 1'b0;
    end else begin
      if (ctl.word_wr) begin
        hold_lo <= wdata[7:0];
        hold_hi <= wdata[15:8];
      end else begin
        if (ctl.lo_wr) hold_lo <= wdata[7:0];
        if (ctl.hi_wr) hold_hi <= wdata[7:0];
      end
      upd <= commit_en && (next_code != code);
      if (commit_en) code <= next_code;
    end
  end
endmodule

// File: rtl/dacif_range.sv
module dacif_range
  import dacif_pkg::*;
#(
  parameter bit HAS_RANGE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [7:0]            wbyte,
  output logic [NUM_CH-1:0][1:0] rng
);
  localparam int unsigned FIELD_LSB = 4;

  generate
    if (HAS_RANGE) begin : g_live
      always_ff @(posedge clk) begin
        if (rst) begin
          rng <= '0;
        end else if (wr) begin
          for (int i = 0; i < NUM_CH; i++) begin
            rng[i] <= wbyte[FIELD_LSB + 2 * i +: 2];
          end
        end
      end
    end else begin : g_fixed
      logic unused_rng;
      assign unused_rng = ^{clk, rst, wr, wbyte};
      assign rng = '0;
    end
  endgenerate
endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
  import dacif_pkg::*;
#(
  parameter int unsigned DAC_BITS   = 16,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned CH_BASE    = 4,
  parameter int unsigned RANGE_ADDR = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                xfer_mode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic                wr_word,
  input  logic [15:0]         wdata,
  input  logic                rd_en,
  output logic [15:0]         rdata,
  output logic [DAC_BITS-1:0] dac0_code,
  output logic [1:0]          dac0_range,
  output logic                dac0_upd,
  output logic [DAC_BITS-1:0] dac1_code,
  output logic [1:0]          dac1_range,
  output logic                dac1_upd
);
  localparam bit HAS_RANGE = (DAC_BITS < HOST_W);

  ch_ctl_t [NUM_CH-1:0]               ctl;
  logic                               rng_wr;
  logic [NUM_CH-1:0][HOST_W-1:0]      hold_w;
  logic [NUM_CH-1:0][DAC_BITS-1:0]    code_w;
  logic [NUM_CH-1:0]                  upd_w;
  logic [NUM_CH-1:0][1:0]             rng_w;
  logic [15:0]                        rd_mux;

  dacif_decode #(
    .ADDR_W    (ADDR_W),
    .CH_BASE   (CH_BASE),
    .RANGE_ADDR(RANGE_ADDR)
  ) u_decode (
    .wr_en  (wr_en),
    .wr_word(wr_word),
    .rd_en  (rd_en),
    .addr   (addr),
    .ctl    (ctl),
    .rng_wr (rng_wr)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dacif_channel #(.DAC_BITS(DAC_BITS)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .xfer_mode(xfer_mode),
        .ctl      (ctl[i]),
        .wdata    (wdata),
        .hold     (hold_w[i]),
        .code     (code_w[i]),
        .upd      (upd_w[i])
      );
    end
  endgenerate

  dacif_range #(.HAS_RANGE(HAS_RANGE)) u_range (
    .clk  (clk),
    .rst  (rst),
    .wr   (rng_wr),
    .wbyte(wdata[7:0]),
    .rng  (rng_w)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(CH_BASE + 2 * i))     rd_mux = hold_w[i];
      if (addr == ADDR_W'(CH_BASE + 2 * i + 1)) rd_mux = {8'h00, hold_w[i][15:8]};
    end
    if (addr == ADDR_W'(RANGE_ADDR)) begin
      for (int i = 0; i < NUM_CH; i++) begin
        rd_mux[4 + 2 * i +: 2] = rng_w[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign dac0_code  = code_w[0];
  assign dac1_code  = code_w[1];
  assign dac0_upd   = upd_w[0];
  assign dac1_upd   = upd_w[1];
  assign dac0_range = rng_w[0];
  assign dac1_range = rng_w[1];
endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk #(
  parameter int unsigned DAC_BITS   = 16,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned CH_BASE    = 4,
  parameter int unsigned RANGE_ADDR = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                xfer_mode,
  input logic [ADDR_W-1:0]   addr,
  input logic                wr_en,
  input logic                wr_word,
  input logic                rd_en,
  input logic [1:0][15:0]    hold_w,
  input logic [DAC_BITS-1:0] dac0_code,
  input logic [DAC_BITS-1:0] dac1_code,
  input logic [1:0]          dac0_range,
  input logic [1:0]          dac1_range,
  input logic                dac0_upd,
  input logic                dac1_upd
);
  logic dac_rd;
  assign dac_rd = rd_en && (addr >= ADDR_W'(CH_BASE)) && (addr <= ADDR_W'(CH_BASE + 3));

  AST_UPD_IMPLIES_CHANGE0: assert property (@(posedge clk) disable iff (rst)
    dac0_upd |-> (dac0_code != $past(dac0_code)));  // R10
  AST_UPD_IMPLIES_CHANGE1: assert property (@(posedge clk) disable iff (rst)
    dac1_upd |-> (dac1_code != $past(dac1_code)));  // R10
  AST_CHANGE_IMPLIES_UPD0: assert property (@(posedge clk) disable iff (rst)
    (dac0_code != $past(dac0_code)) |-> dac0_upd);  // R10
  AST_XFER_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (xfer_mode && !rd_en) |=> ($stable(dac0_code) && $stable(dac1_code)));  // R5
  AST_INDIV_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!xfer_mode && !wr_en) |=> ($stable(dac0_code) && $stable(dac1_code)));  // R3
  AST_JOINT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (xfer_mode && dac_rd) |=> ((dac0_code == $past(hold_w[0][15 -: DAC_BITS])) &&
                               (dac1_code == $past(hold_w[1][15 -: DAC_BITS]))));  // R5
  AST_LOW_BYTE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_word && !rd_en && addr == ADDR_W'(CH_BASE)) |=> $stable(dac0_code));  // R2
  AST_RANGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == ADDR_W'(RANGE_ADDR)) |=> ($stable(dac0_range) && $stable(dac1_range)));  // R8
endmodule

bind dual_dac_regs dual_dac_regs_chk #(
  .DAC_BITS  (DAC_BITS),
  .ADDR_W    (ADDR_W),
  .CH_BASE   (CH_BASE),
  .RANGE_ADDR(RANGE_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .xfer_mode (xfer_mode),
  .addr      (addr),
  .wr_en     (wr_en),
  .wr_word   (wr_word),
  .rd_en     (rd_en),
  .hold_w    (hold_w),
  .dac0_code (dac0_code),
  .dac1_code (dac1_code),
  .dac0_range(dac0_range),
  .dac1_range(dac1_range),
  .dac0_upd  (dac0_upd),
  .dac1_upd  (dac1_upd)
);

// File: tb/tb_dual_dac_regs.sv
module tb_dual_dac_regs;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, xfer, wr_en, wr_word, rd_en;
  logic [3:0]  addr;
  logic [15:0] wdata;

  logic [15:0] rd16, rd12, c0_16, c1_16;
  logic [11:0] c0_12, c1_12;
  logic [1:0]  g0_16, g1_16, g0_12, g1_12;
  logic        u0_16, u1_16, u0_12, u1_12;

  dual_dac_regs #(.DAC_BITS(16)) dut (
    .clk(clk), .rst(rst), .xfer_mode(xfer), .addr(addr), .wr_en(wr_en),
    .wr_word(wr_word), .wdata(wdata), .rd_en(rd_en), .rdata(rd16),
    .dac0_code(c0_16), .dac0_range(g0_16), .dac0_upd(u0_16),
    .dac1_code(c1_16), .dac1_range(g1_16), .dac1_upd(u1_16));

  dual_dac_regs #(.DAC_BITS(12)) dut12 (
    .clk(clk), .rst(rst), .xfer_mode(xfer), .addr(addr), .wr_en(wr_en),
    .wr_word(wr_word), .wdata(wdata), .rd_en(rd_en), .rdata(rd12),
    .dac0_code(c0_12), .dac0_range(g0_12), .dac0_upd(u0_12),
    .dac1_code(c1_12), .dac1_range(g1_12), .dac1_upd(u1_12));

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [15:0] hold [2];
  logic [15:0] cur  [2];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic ww, input logic re,
                    input logic [3:0] a, input logic [15:0] d);
    wr_en = we; wr_word = ww; rd_en = re; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wr_word = 1'b0; rd_en = 1'b0;
  endtask

  task automatic chk_codes(input string req);
    chk(req, c0_16, cur[0]);
    chk(req, c1_16, cur[1]);
    chk(req, c0_12, cur[0][15:4]);
    chk(req, c1_12, cur[1][15:4]);
  endtask

  function automatic logic upd16(input int ch);
    return ch == 0 ? u0_16 : u1_16;
  endfunction
  function automatic logic upd12(input int ch);
    return ch == 0 ? u0_12 : u1_12;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; xfer = 1'b0; wr_en = 1'b0; wr_word = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0;
    for (int i = 0; i < 2; i++) begin hold[i] = '0; cur[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_codes("R1");
    chk("R1", {g0_16, g1_16, g0_12, g1_12}, 0);
    chk("R1", {u0_16, u1_16, u0_12, u1_12}, 0);
    chk("R1", {rd16, rd12}, 0);

    // R2 / R3 / R10 / R7: byte writes in individual mode
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 16; k++) begin
        logic [15:0] v, old;
        v   = 16'(k * 16'h1357 + ch * 16'h0808) ^ 16'hA5C3;
        old = cur[ch];
        op(1, 0, 0, 4'(4 + 2 * ch), {8'h00, v[7:0]});
        hold[ch][7:0] = v[7:0];
        chk_codes("R2");
        chk("R2", {u0_16, u1_16, u0_12, u1_12}, 0);
        op(1, 0, 0, 4'(5 + 2 * ch), {8'h00, v[15:8]});
        hold[ch] = v; cur[ch] = v;
        chk_codes("R3");
        chk("R10", upd16(ch), (v != old));
        chk("R7", upd12(ch), (v[15:4] != old[15:4]));
        op(1, 0, 0, 4'(5 + 2 * ch), {8'h00, v[15:8]});
        chk("R10", {upd16(ch), upd12(ch)}, 0);
      end
    end

    // R3 / R11: reads do not commit in individual mode; readback layout
    op(1, 0, 0, 4'd4, 16'h00E1);
    hold[0][7:0] = 8'hE1;
    op(0, 0, 1, 4'd4, 16'h0);
    chk_codes("R3");
    chk("R11", rd16, hold[0]);
    op(0, 0, 1, 4'd7, 16'h0);
    chk_codes("R3");
    chk("R11", rd12, {8'h00, hold[1][15:8]});
    op(0, 0, 1, 4'd2, 16'h0);
    chk("R11", rd16, 16'h0000);

    // R4: word writes commit at once
    for (int k = 0; k < 8; k++) begin
      int ch = k % 2;
      logic [15:0] v;
      v = 16'(k * 16'h2F1D) ^ 16'h6B00;
      op(1, 1, 0, 4'(4 + 2 * ch), v);
      hold[ch] = v; cur[ch] = v;
      chk_codes("R4");
    end

    // R7: low nibble ignored by the 12-bit variant
    op(1, 1, 0, 4'd4, 16'h8420);
    hold[0] = 16'h8420; cur[0] = 16'h8420;
    op(1, 1, 0, 4'd4, 16'h842F);
    hold[0] = 16'h842F; cur[0] = 16'h842F;
    chk("R7", c0_12, 12'h842);
    chk("R7", u0_12, 1'b0);
    chk("R7", {c0_16, 15'h0, u0_16}, {16'h842F, 15'h0, 1'b1});

    // R5: joint commit on a read at each converter offset
    xfer = 1'b1;
    for (int k = 0; k < 8; k++) begin
      logic [15:0] a, b, o0, o1;
      a = 16'(k * 16'h1111 + 16'h0F0F);
      b = 16'(k * 16'h3030 + 16'h7001);
      o0 = cur[0]; o1 = cur[1];
      op(1, 1, 0, 4'd4, a);
      op(1, 0, 0, 4'd7, {8'h00, b[15:8]});
      op(1, 0, 0, 4'd6, {8'h00, b[7:0]});
      hold[0] = a; hold[1] = b;
      chk_codes("R5");
      op(0, 0, 1, 4'(4 + (k % 4)), 16'h0);
      cur[0] = a; cur[1] = b;
      chk_codes("R5");
      chk("R5", {u0_16, u1_16}, {a != o0, b != o1});
    end

    // R6: commit read and holding write in the same cycle
    op(1, 1, 0, 4'd4, 16'h3C5A);
    hold[0] = 16'h3C5A;
    op(1, 1, 1, 4'd4, 16'hC3A5);
    cur[0] = 16'h3C5A; cur[1] = hold[1];
    chk_codes("R6");
    hold[0] = 16'hC3A5;
    op(0, 0, 1, 4'd5, 16'h0);
    cur[0] = 16'hC3A5;
    chk_codes("R6");
    xfer = 1'b0;

    // R8 / R9: range register sweep
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bb;
      bb = 8'(b);
      op(1, 0, 0, 4'd10, {8'h00, bb});
      chk("R8", {g1_12, g0_12}, {bb[7:6], bb[5:4]});
      chk("R9", {g1_16, g0_16}, 4'h0);
    end
    op(0, 0, 1, 4'd10, 16'h0);
    chk("R11", rd12, 16'h00F0);
    op(1, 1, 0, 4'd6, 16'h0012);
    hold[1] = 16'h0012; cur[1] = 16'h0012;
    chk("R8", {g1_12, g0_12}, 4'hF);
    chk_codes("R4");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule